// File: doc/BRIEF.md
# Paging Codeword End-of-Message Detector

This block sits after bit and word alignment in a paging receiver. It takes one aligned 32-bit codeword at a time, marked by a valid strobe, and follows whether a message is in progress. A message opens when an address-type codeword arrives. It closes on any of three events. The first is the fixed idle codeword, matched with up to two wrong bits. The second is a fresh address codeword. The third is an abort from the host processor.

Each closing event produces a one-cycle end-of-message pulse with a 2-bit cause code. Message-type codewords received while a message is open are passed on with their own strobe to the downstream error-correction stage. The idle pattern, word width and error tolerance are parameters. A second parameter picks between two forms of the bit-difference counter.

Top module: `pgr_eom_detect`

## Requirements
- R1: After reset, `msg_active`, `eom_pulse` and `msg_valid` are 0 and `eom_cause` is 2'b00.
- R2: An address-type codeword arriving while no message is open sets `msg_active` one cycle after its strobe, and no end pulse is produced. A word is address-type when its most significant bit (bit 31, the first bit received) is 0 and it is not an idle match.
- R3: A message-type codeword (bit 31 = 1, not an idle match) arriving while a message is open appears on `msg_data` with `msg_valid` high for one cycle, one cycle after its strobe. When no message is open it is dropped.
- R4: A codeword that differs from 32'h7A89C197 in 2 or fewer bit positions is an idle match. Arriving while a message is open, it produces `eom_pulse` with cause 2'b01 one cycle later and clears `msg_active`.
- R5: A codeword with 3 or more bits different from the idle pattern is not an idle match and is classified by bit 31 alone.
- R6: An address-type codeword arriving while a message is open produces `eom_pulse` with cause 2'b10. `msg_active` stays 1, because the new address opens the next message.
- R7: `host_abort` high while a message is open produces `eom_pulse` with cause 2'b11 one cycle later and clears `msg_active`. While no message is open, `host_abort` produces no pulse.
- R8: When `host_abort` and `cw_valid` are high in the same cycle, the abort wins. The codeword is neither forwarded nor allowed to open a message.
- R9: An idle match arriving while no message is open produces no pulse and leaves `msg_active` at 0.
- R10: `eom_pulse` lasts one cycle for each event, and `eom_cause` is 2'b00 whenever `eom_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Codeword strobe |
| cw_data | input | 32 | Aligned codeword, bit 31 received first |
| host_abort | input | 1 | Host request to end the current message |
| msg_active | output | 1 | A message is open |
| eom_pulse | output | 1 | One-cycle end-of-message pulse |
| eom_cause | output | 2 | 01 idle, 10 new address, 11 host abort, 00 none |
| msg_valid | output | 1 | Forwarded message codeword strobe |
| msg_data | output | 32 | Forwarded message codeword |

## Verification
The assertions assume that `cw_valid` and `host_abort` are synchronous to `clk` and hold stable across the sampling edge. They also assume `cw_data` is settled whenever the strobe is high, and that reset is applied before the first codeword. The bench changes every input on the falling edge and holds each strobe for exactly one cycle. Every word it sends is chosen for a known distance from the idle pattern, with 0, 2 or 3 flipped bits and a known bit 31, so each classification is decided ahead of time.

// File: rtl/pgr_eom_pkg.sv
package pgr_eom_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_IDLE  = 2'b01,
      CAUSE_ADDR  = 2'b10,
      CAUSE_ABORT = 2'b11
   } eom_cause_e;

   typedef struct packed {
      logic idle_hit;
      logic addr_type;
      logic msg_type;
   } cw_class_t;

endpackage

// File: rtl/pgr_idle_match.sv
// Counts the bits in which a codeword differs from the idle pattern and
// reports a hit when that count stays within the tolerance.
module pgr_idle_match #(
   parameter int          WORD_W    = 32,
   parameter logic [31:0] IDLE_PAT  = 32'h7A89C197,
   parameter int          MAX_ERR   = 2,
   parameter bit          SAT_COUNT = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   output logic              hit
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ERR);

   logic [WORD_W-1:0] diff;
   assign diff = word ^ IDLE_PAT[WORD_W-1:0];

   generate
      if (MAX_ERR < 0 || MAX_ERR >= WORD_W / 2) begin : g_bad_err
         $error("pgr_idle_match: MAX_ERR out of range");
      end
      if (WORD_W > 32 || WORD_W < 2) begin : g_bad_w
         $error("pgr_idle_match: WORD_W must lie in 2..32");
      end

      if (SAT_COUNT) begin : g_sat
         // Counter stops at LIMIT+1, so it needs no more range than that.
         logic [CNT_W-1:0] cnt;
         always_comb begin
            cnt = '0;
            for (int i = 0; i < WORD_W; i++) begin
               if (diff[i] && (cnt <= LIMIT)) cnt = cnt + CNT_W'(1);
            end
         end
         assign hit = (cnt <= LIMIT);
      end else begin : g_full
         logic [CNT_W-1:0] cnt;
         always_comb begin
            cnt = '0;
            for (int i = 0; i < WORD_W; i++) begin
               cnt = cnt + CNT_W'(diff[i]);
            end
         end
         assign hit = (cnt <= LIMIT);
      end
   endgenerate

   always_comb begin
      if (diff == '0) assert_exact_idle_hits_R4: assert (hit);
   end
endmodule

// File: rtl/pgr_word_class.sv
// Sorts a codeword into idle, address or message type. The idle check
// comes first; otherwise the first received bit decides.
module pgr_word_class
   import pgr_eom_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter logic [31:0] IDLE_PAT  = 32'h7A89C197,
   parameter int          MAX_ERR   = 2,
   parameter bit          SAT_COUNT = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   output cw_class_t         cls
);
   localparam int FLAG_BIT = WORD_W - 1;

   logic idle_hit;

   pgr_idle_match #(
      .WORD_W   (WORD_W),
      .IDLE_PAT (IDLE_PAT),
      .MAX_ERR  (MAX_ERR),
      .SAT_COUNT(SAT_COUNT)
   ) u_idle (
      .word(word),
      .hit (idle_hit)
   );

   always_comb begin
      cls.idle_hit  = idle_hit;
      cls.addr_type = !idle_hit && !word[FLAG_BIT];
      cls.msg_type  = !idle_hit &&  word[FLAG_BIT];
   end

   always_comb begin
      assert_class_exclusive_R5: assert ($onehot({cls.idle_hit, cls.addr_type, cls.msg_type}));
   end
endmodule

// File: rtl/pgr_eom_ctrl.sv
// Message state, end-of-message events and message-word forwarding.
module pgr_eom_ctrl
   import pgr_eom_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_valid,
   input  logic [WORD_W-1:0] cw_data,
   input  cw_class_t         cls,
   input  logic              host_abort,
   output logic              msg_active,
   output logic              eom_pulse,
   output eom_cause_e        eom_cause,
   output logic              msg_valid,
   output logic [WORD_W-1:0] msg_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_active <= 1'b0;
         eom_pulse  <= 1'b0;
         eom_cause  <= CAUSE_NONE;
         msg_valid  <= 1'b0;
         msg_data   <= '0;
      end else begin
         eom_pulse <= 1'b0;
         eom_cause <= CAUSE_NONE;
         msg_valid <= 1'b0;
         if (host_abort) begin
            if (msg_active) begin
               eom_pulse <= 1'b1;
               eom_cause <= CAUSE_ABORT;
            end
            msg_active <= 1'b0;
         end else if (cw_valid) begin
            if (cls.idle_hit) begin
               if (msg_active) begin
                  eom_pulse <= 1'b1;
                  eom_cause <= CAUSE_IDLE;
               end
               msg_active <= 1'b0;
            end else if (cls.addr_type) begin
               if (msg_active) begin
                  eom_pulse <= 1'b1;
                  eom_cause <= CAUSE_ADDR;
               end
               msg_active <= 1'b1;
            end else if (msg_active) begin
               msg_valid <= 1'b1;
               msg_data  <= cw_data;
            end
         end
      end
   end

   assert_abort_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_abort && msg_active) |=> (eom_pulse && eom_cause == CAUSE_ABORT && !msg_active));

   assert_abort_blocks_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_abort |=> (!msg_valid && !msg_active));

   assert_idle_when_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid && !host_abort && cls.idle_hit && !msg_active) |=> (!eom_pulse && !msg_active));

   assert_forward_inside_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $past(msg_active));

   assert_idle_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eom_pulse && eom_cause == CAUSE_IDLE) |-> !msg_active);

   assert_addr_reopens_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid && !host_abort && cls.addr_type) |=> msg_active);

   assert_cause_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !eom_pulse |-> (eom_cause == CAUSE_NONE));
endmodule

// File: rtl/pgr_eom_detect.sv
module pgr_eom_detect
   import pgr_eom_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter logic [31:0] IDLE_PAT  = 32'h7A89C197,
   parameter int          MAX_ERR   = 2,
   parameter bit          SAT_COUNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_valid,
   input  logic [WORD_W-1:0] cw_data,
   input  logic              host_abort,
   output logic              msg_active,
   output logic              eom_pulse,
   output logic [1:0]        eom_cause,
   output logic              msg_valid,
   output logic [WORD_W-1:0] msg_data
);
   cw_class_t  cls;
   eom_cause_e cause_q;

   pgr_word_class #(
      .WORD_W   (WORD_W),
      .IDLE_PAT (IDLE_PAT),
      .MAX_ERR  (MAX_ERR),
      .SAT_COUNT(SAT_COUNT)
   ) u_class (
      .word(cw_data),
      .cls (cls)
   );

   pgr_eom_ctrl #(
      .WORD_W(WORD_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cw_valid  (cw_valid),
      .cw_data   (cw_data),
      .cls       (cls),
      .host_abort(host_abort),
      .msg_active(msg_active),
      .eom_pulse (eom_pulse),
      .eom_cause (cause_q),
      .msg_valid (msg_valid),
      .msg_data  (msg_data)
   );

   assign eom_cause = cause_q;
endmodule

// File: tb/tb_pgr_eom_detect.sv
module tb_pgr_eom_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cw_valid = 1'b0;
   logic [31:0] cw_data = '0;
   logic        host_abort = 1'b0;
   logic        msg_active, eom_pulse, msg_valid;
   logic [1:0]  eom_cause;
   logic [31:0] msg_data;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [31:0] IDLE   = 32'h7A89C197;
   localparam logic [31:0] IDLE2  = 32'h7A88C196; // two bits off
   localparam logic [31:0] NEAR_M = 32'hFA89C194; // three off, bit31=1
   localparam logic [31:0] NEAR_A = 32'h7A89C190; // three off, bit31=0
   localparam logic [31:0] ADDR   = 32'h12345678;
   localparam logic [31:0] MSGW   = 32'h9ABCDEF0;

   always #10 clk = ~clk;

   pgr_eom_detect dut (
      .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_data(cw_data),
      .host_abort(host_abort), .msg_active(msg_active), .eom_pulse(eom_pulse),
      .eom_cause(eom_cause), .msg_valid(msg_valid), .msg_data(msg_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus; returns after the capturing edge.
   task automatic step(input logic v, input logic [31:0] d, input logic ab);
      @(negedge clk);
      cw_valid = v; cw_data = d; host_abort = ab;
      @(negedge clk);
      cw_valid = 1'b0; host_abort = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 active", 32'(msg_active), 0);
      chk("R1 pulse", 32'(eom_pulse), 0);
      chk("R1 fwd", 32'(msg_valid), 0);
      chk("R10 cause at reset", 32'(eom_cause), 0);
   endtask

   task automatic t_closed_ignores;
      step(1, MSGW, 0);
      chk("R3 msg dropped when closed", 32'(msg_valid), 0);
      step(1, IDLE, 0);
      chk("R9 idle closed pulse", 32'(eom_pulse), 0);
      chk("R9 idle closed active", 32'(msg_active), 0);
   endtask

   task automatic t_open_forward;
      step(1, ADDR, 0);
      chk("R2 open", 32'(msg_active), 1);
      chk("R2 no pulse", 32'(eom_pulse), 0);
      step(1, MSGW, 0);
      chk("R3 fwd valid", 32'(msg_valid), 1);
      chk("R3 fwd data", msg_data, MSGW);
      step(0, 0, 0);
      chk("R3 fwd one cycle", 32'(msg_valid), 0);
   endtask

   task automatic t_idle_close;
      step(1, IDLE2, 0);
      chk("R4 pulse", 32'(eom_pulse), 1);
      chk("R4 cause", 32'(eom_cause), 32'h1);
      chk("R4 closed", 32'(msg_active), 0);
      step(0, 0, 0);
      chk("R10 pulse one cycle", 32'(eom_pulse), 0);
      chk("R10 cause cleared", 32'(eom_cause), 0);
      step(1, ADDR, 0);
      step(1, IDLE, 0);
      chk("R4 exact idle cause", 32'(eom_cause), 32'h1);
   endtask

   task automatic t_near_idle;
      step(1, ADDR, 0);
      step(1, NEAR_M, 0);
      chk("R5 near-idle msg no pulse", 32'(eom_pulse), 0);
      chk("R5 near-idle msg forwarded", msg_data, NEAR_M);
      chk("R5 near-idle msg valid", 32'(msg_valid), 1);
      step(1, NEAR_A, 0);
      chk("R5 R6 near-idle addr cause", 32'(eom_cause), 32'h2);
      chk("R6 pulse", 32'(eom_pulse), 1);
      chk("R6 stays open", 32'(msg_active), 1);
      step(1, ADDR, 0);
      chk("R6 back-to-back addr cause", 32'(eom_cause), 32'h2);
      step(0, 0, 0);
      chk("R10 quiet after addr", 32'(eom_pulse), 0);
   endtask

   task automatic t_abort;
      step(0, 0, 1);
      chk("R7 pulse", 32'(eom_pulse), 1);
      chk("R7 cause", 32'(eom_cause), 32'h3);
      chk("R7 closed", 32'(msg_active), 0);
      step(0, 0, 1);
      chk("R7 closed abort no pulse", 32'(eom_pulse), 0);
   endtask

   task automatic t_collide;
      step(1, ADDR, 0);
      step(1, MSGW, 1);
      chk("R8 abort cause", 32'(eom_cause), 32'h3);
      chk("R8 word not forwarded", 32'(msg_valid), 0);
      chk("R8 closed", 32'(msg_active), 0);
      step(1, ADDR, 1);
      chk("R8 addr blocked", 32'(msg_active), 0);
      chk("R8 no pulse", 32'(eom_pulse), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_closed_ignores();
      t_open_forward();
      t_idle_close();
      t_near_idle();
      t_abort();
      t_collide();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule